// File: doc/BRIEF.md
# Paired Double-Buffered Bulk IN Endpoint Controller

This block keeps the buffer bookkeeping for a bulk IN endpoint (the "even" endpoint) and its odd-numbered neighbour. When pairing is switched on, the two packet buffers behind the pair act as one double-buffered endpoint. The CPU sees only the even endpoint's byte-count register and flags. Writing the byte count hands over the buffer just loaded. The USB side is told which physical buffer to send and how long the packet is. When pairing is off, each endpoint runs single-buffered on its own buffer.

The CPU reads a busy flag, an overflow flag and a sticky interrupt request for each endpoint. Busy tells software that no buffer is free for loading. The interrupt tells software that a packet left the chip. A full clear is done in software: two byte-count writes, then busy is cleared on both endpoints. This sequence always returns the pair to the empty state. The USB protocol engine, the packet data path and the buffer RAM sit outside the block.

Top module: `pair_in_ep`

## Requirements
- R1: After reset, no buffer is full and every busy, ready, overflow and interrupt output is 0.
- R2: In paired mode, each accepted even byte-count write commits one packet. `usb_even_rdy` is 1 while `even_valid` is 1 and at least one packet is pending. Packets go out first in, first out with the committed length. `usb_even_buf` starts at 0 (the even buffer) and alternates 0, 1, 0, ... on each commit and each send.
- R3: In paired mode, `even_busy` is 1 only when two packets are pending. It is 0 when one or both buffers are free.
- R4: A send is `usb_even_sent` while `usb_even_rdy`. It frees one buffer. With two buffers full, busy falls to 0. With one full, busy stays 0.
- R5: Every send sets the endpoint's sticky interrupt pending bit. Writing 1 to its clear input resets the bit, but a send in the same cycle wins. The interrupt output is the pending bit ANDed with the endpoint's enable.
- R6: A byte-count write while busy is 1 leaves the buffers unchanged and sets the sticky overflow flag.
- R7: An even busy clear empties the endpoint at once. It drops all pending packets, puts the next buffer back to 0 and clears the overflow flag. It also wins over a byte-count write in the same cycle. So two writes followed by a busy clear on both endpoints leave the pair empty.
- R8: In paired mode, the odd endpoint's valid, enable, byte-count write, busy clear, interrupt clear and sent inputs have no effect. All odd outputs read 0.
- R9: In unpaired mode, each endpoint is single-buffered. A byte-count write sets busy and a send clears it. Every send raises that endpoint's interrupt. The even endpoint always uses buffer 0.
- R10: A sent strobe while the endpoint is not ready changes nothing and raises no interrupt.
- R11: Changing the pairing mode empties the even endpoint and returns its pointers to buffer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_en | input | 1 | Pair the even and odd buffers as one endpoint |
| even_valid | input | 1 | Even endpoint valid |
| even_ie | input | 1 | Even interrupt enable |
| even_bc_we | input | 1 | Even byte-count write strobe |
| even_bc_wdata | input | LEN_W | Even byte-count value |
| even_busy_clr | input | 1 | Even busy clear |
| even_irq_clr | input | 1 | Even interrupt clear (write 1) |
| even_busy | output | 1 | Even busy flag |
| even_ovf | output | 1 | Even overflow flag |
| even_irq | output | 1 | Even interrupt request |
| usb_even_rdy | output | 1 | Even endpoint has a packet to send |
| usb_even_len | output | LEN_W | Length of the packet to send |
| usb_even_buf | output | 1 | Physical buffer to send: 0 even, 1 odd |
| usb_even_sent | input | 1 | Even packet sent successfully |
| odd_valid | input | 1 | Odd endpoint valid |
| odd_ie | input | 1 | Odd interrupt enable |
| odd_bc_we | input | 1 | Odd byte-count write strobe |
| odd_bc_wdata | input | LEN_W | Odd byte-count value |
| odd_busy_clr | input | 1 | Odd busy clear |
| odd_irq_clr | input | 1 | Odd interrupt clear (write 1) |
| odd_busy | output | 1 | Odd busy flag |
| odd_ovf | output | 1 | Odd overflow flag |
| odd_irq | output | 1 | Odd interrupt request |
| usb_odd_rdy | output | 1 | Odd endpoint has a packet to send |
| usb_odd_len | output | LEN_W | Odd packet length |
| usb_odd_sent | input | 1 | Odd packet sent successfully |

## Verification
The assertions check these rules on every cycle:
- busy implies ready on a valid paired endpoint;
- an overflowing write sets the sticky flag;
- each send leaves an interrupt pending;
- a send from two full buffers drops busy;
- a force clear leaves the endpoint empty;
- the odd outputs stay silent while paired;
- an unpaired odd write sets its busy.

Only the bench scenarios can show that packets leave in commit order with the right length and alternating buffer. They also show that the odd inputs leave the even state untouched, that a send beats an interrupt clear, that strobes with nothing pending are ignored, and that a mode change flushes the endpoint.

// File: rtl/pair_in_ep.sv
module pair_in_ep #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_en,
  input  logic             even_valid,
  input  logic             even_ie,
  input  logic             even_bc_we,
  input  logic [LEN_W-1:0] even_bc_wdata,
  input  logic             even_busy_clr,
  input  logic             even_irq_clr,
  output logic             even_busy,
  output logic             even_ovf,
  output logic             even_irq,
  output logic             usb_even_rdy,
  output logic [LEN_W-1:0] usb_even_len,
  output logic             usb_even_buf,
  input  logic             usb_even_sent,
  input  logic             odd_valid,
  input  logic             odd_ie,
  input  logic             odd_bc_we,
  input  logic [LEN_W-1:0] odd_bc_wdata,
  input  logic             odd_busy_clr,
  input  logic             odd_irq_clr,
  output logic             odd_busy,
  output logic             odd_ovf,
  output logic             odd_irq,
  output logic             usb_odd_rdy,
  output logic [LEN_W-1:0] usb_odd_len,
  input  logic             usb_odd_sent
);

  localparam int NBUF = 2;
  localparam int CW   = $clog2(NBUF + 1);

  logic [CW-1:0]    ev_cnt;
  logic             ev_wp, ev_rp;
  logic [LEN_W-1:0] ev_len [NBUF];
  logic             ev_irq_q, ev_ovf_q, pair_q;
  logic             od_full, od_irq_q, od_ovf_q;
  logic [LEN_W-1:0] od_len;

  logic [CW-1:0] ev_cap;
  logic          mode_chg, ev_full, ev_send, ev_take, ev_rej;
  logic          od_send, od_take, od_rej;

  assign ev_cap   = pair_en ? CW'(NBUF) : CW'(1);
  assign mode_chg = pair_en != pair_q;
  assign ev_full  = ev_cnt >= ev_cap;
  assign ev_send  = usb_even_sent && usb_even_rdy;
  assign ev_take  = even_bc_we && !ev_full && !even_busy_clr && !mode_chg;
  assign ev_rej   = even_bc_we &&  ev_full && !even_busy_clr && !mode_chg;

  assign even_busy    = ev_full;
  assign even_ovf     = ev_ovf_q;
  assign even_irq     = ev_irq_q && even_ie;
  assign usb_even_rdy = even_valid && (ev_cnt != '0);
  assign usb_even_len = ev_len[ev_rp];
  assign usb_even_buf = ev_rp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_cnt   <= '0;
      ev_wp    <= 1'b0;
      ev_rp    <= 1'b0;
      ev_irq_q <= 1'b0;
      ev_ovf_q <= 1'b0;
      pair_q   <= 1'b0;
      for (int i = 0; i < NBUF; i++) ev_len[i] <= '0;
    end else begin
      pair_q <= pair_en;
      if (mode_chg || even_busy_clr) begin
        ev_cnt <= '0;
        ev_wp  <= 1'b0;
        ev_rp  <= 1'b0;
      end else begin
        if (ev_take) begin
          ev_len[ev_wp] <= even_bc_wdata;
          if (pair_en) ev_wp <= ~ev_wp;
        end
        if (ev_send && pair_en) ev_rp <= ~ev_rp;
        ev_cnt <= ev_cnt + CW'(ev_take) - CW'(ev_send);
      end
      if (even_busy_clr)  ev_ovf_q <= 1'b0;
      else if (ev_rej)    ev_ovf_q <= 1'b1;
      if (ev_send)           ev_irq_q <= 1'b1;
      else if (even_irq_clr) ev_irq_q <= 1'b0;
    end
  end

  assign od_send = usb_odd_sent && usb_odd_rdy;
  assign od_take = odd_bc_we && !od_full && !odd_busy_clr && !pair_en;
  assign od_rej  = odd_bc_we &&  od_full && !odd_busy_clr && !pair_en;

  assign odd_busy    = od_full && !pair_en;
  assign odd_ovf     = od_ovf_q && !pair_en;
  assign odd_irq     = od_irq_q && odd_ie && !pair_en;
  assign usb_odd_rdy = odd_valid && od_full && !pair_en;
  assign usb_odd_len = od_len;

  always_ff @(posedge clk) begin
    if (!rst_n || pair_en) begin
      od_full  <= 1'b0;
      od_irq_q <= 1'b0;
      od_ovf_q <= 1'b0;
      od_len   <= '0;
    end else begin
      if (odd_busy_clr) od_full <= 1'b0;
      else if (od_take) od_full <= 1'b1;
      else if (od_send) od_full <= 1'b0;
      if (od_take) od_len <= odd_bc_wdata;
      if (odd_busy_clr) od_ovf_q <= 1'b0;
      else if (od_rej)  od_ovf_q <= 1'b1;
      if (od_send)          od_irq_q <= 1'b1;
      else if (odd_irq_clr) od_irq_q <= 1'b0;
    end
  end

  assert_busy_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_en && even_busy && even_valid) |-> usb_even_rdy);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (even_bc_we && even_busy && !even_busy_clr && !mode_chg) |=> even_ovf);

  assert_irq_on_send_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_even_sent && usb_even_rdy) |=> ev_irq_q);

  assert_busy_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_en && pair_q && even_busy && usb_even_sent && usb_even_rdy && !even_bc_we)
    |=> (!even_busy || !pair_en));

  assert_force_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_en && even_busy_clr) |=> (!even_busy && !usb_even_rdy && !even_ovf));

  assert_odd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_en |-> (!odd_busy && !odd_irq && !odd_ovf && !usb_odd_rdy));

  assert_odd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_en && odd_bc_we && !odd_busy && !odd_busy_clr) |=> (odd_busy || pair_en));

endmodule

// File: tb/sim_pair_in_ep.sv
module sim_pair_in_ep;
  localparam int LW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pair_en = 0, even_valid = 0, even_ie = 0, even_bc_we = 0;
  logic [LW-1:0] even_bc_wdata = '0;
  logic even_busy_clr = 0, even_irq_clr = 0, usb_even_sent = 0;
  logic odd_valid = 0, odd_ie = 0, odd_bc_we = 0, odd_busy_clr = 0, odd_irq_clr = 0, usb_odd_sent = 0;
  logic [LW-1:0] odd_bc_wdata = '0;
  logic even_busy, even_ovf, even_irq, usb_even_rdy, usb_even_buf;
  logic odd_busy, odd_ovf, odd_irq, usb_odd_rdy;
  logic [LW-1:0] usb_even_len, usb_odd_len;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  pair_in_ep #(.LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .pair_en(pair_en),
    .even_valid(even_valid), .even_ie(even_ie), .even_bc_we(even_bc_we),
    .even_bc_wdata(even_bc_wdata), .even_busy_clr(even_busy_clr), .even_irq_clr(even_irq_clr),
    .even_busy(even_busy), .even_ovf(even_ovf), .even_irq(even_irq),
    .usb_even_rdy(usb_even_rdy), .usb_even_len(usb_even_len), .usb_even_buf(usb_even_buf),
    .usb_even_sent(usb_even_sent),
    .odd_valid(odd_valid), .odd_ie(odd_ie), .odd_bc_we(odd_bc_we), .odd_bc_wdata(odd_bc_wdata),
    .odd_busy_clr(odd_busy_clr), .odd_irq_clr(odd_irq_clr),
    .odd_busy(odd_busy), .odd_ovf(odd_ovf), .odd_irq(odd_irq),
    .usb_odd_rdy(usb_odd_rdy), .usb_odd_len(usb_odd_len), .usb_odd_sent(usb_odd_sent)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ev_write(int len, bit taken, bit b);
    even_bc_wdata = LW'(len);
    even_bc_we = 1;
    if (taken) exp_q.push_back(b * 256 + len);
    cyc();
    even_bc_we = 0;
  endtask

  task automatic ev_send();
    usb_even_sent = 1;
    cyc();
    usb_even_sent = 0;
  endtask

  // monitor: compares every accepted send against the scoreboard
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n && usb_even_sent && usb_even_rdy) begin
      if (exp_q.size() == 0) check("R2 unexpected send", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check("R2 length", int'(usb_even_len), e % 256);
        check("R2 buffer", int'(usb_even_buf), e / 256);
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc();
    check("R1 busy", even_busy, 0);
    check("R1 rdy", usb_even_rdy, 0);
    check("R1 irq", even_irq | odd_irq, 0);
    check("R1 ovf", even_ovf | odd_ovf, 0);

    pair_en = 1; even_valid = 1; even_ie = 1;
    cyc(2);
    ev_write(10, 1, 0);
    check("R2 rdy one", usb_even_rdy, 1);
    check("R3 busy one", even_busy, 0);
    ev_write(20, 1, 1);
    check("R3 busy two", even_busy, 1);
    ev_write(30, 0, 0);
    check("R6 ovf", even_ovf, 1);
    check("R6 busy kept", even_busy, 1);
    ev_send();
    check("R4 busy falls", even_busy, 0);
    check("R5 irq", even_irq, 1);
    even_irq_clr = 1; cyc(); even_irq_clr = 0;
    check("R5 irq clear", even_irq, 0);
    ev_send();
    check("R4 busy stays", even_busy, 0);
    check("R4 rdy empty", usb_even_rdy, 0);
    check("R5 irq again", even_irq, 1);
    even_ie = 0; cyc();
    check("R5 enable mask", even_irq, 0);
    even_ie = 1;
    even_irq_clr = 1; cyc(); even_irq_clr = 0;

    // R10: strobe with nothing pending
    ev_send();
    check("R10 irq", even_irq, 0);
    check("R10 busy", even_busy, 0);

    // R2: interleaved order, buffers continue from 0
    ev_write(5, 1, 0);
    ev_write(6, 1, 1);
    ev_send();
    ev_write(7, 1, 0);
    check("R3 busy refill", even_busy, 1);
    even_irq_clr = 1; usb_even_sent = 1; cyc();
    even_irq_clr = 0; usb_even_sent = 0;
    check("R5 send beats clear", even_irq, 1);
    ev_send();
    check("R2 drained", usb_even_rdy, 0);

    // R8: odd inputs have no effect while paired
    ev_write(11, 1, 1);
    odd_valid = 1; odd_ie = 1; odd_bc_we = 1; odd_bc_wdata = 9;
    odd_busy_clr = 1; odd_irq_clr = 1; usb_odd_sent = 1;
    cyc(2);
    odd_bc_we = 0; odd_busy_clr = 0; odd_irq_clr = 0; usb_odd_sent = 0;
    check("R8 odd busy", odd_busy, 0);
    check("R8 odd rdy", usb_odd_rdy, 0);
    check("R8 odd irq", odd_irq, 0);
    check("R8 even rdy", usb_even_rdy, 1);
    check("R8 even busy", even_busy, 0);
    ev_write(12, 1, 0);
    check("R8 one was pending", even_busy, 1);

    // R7: force clear
    ev_write(1, 0, 0);
    ev_write(2, 0, 0);
    check("R7 ovf before", even_ovf, 1);
    even_busy_clr = 1; odd_busy_clr = 1; cyc();
    even_busy_clr = 0; odd_busy_clr = 0;
    exp_q.delete();
    check("R7 busy", even_busy, 0);
    check("R7 rdy", usb_even_rdy, 0);
    check("R7 ovf", even_ovf, 0);
    ev_write(40, 1, 0);
    ev_send();

    // R11: mode change flushes
    ev_write(41, 1, 1);
    pair_en = 0; cyc();
    exp_q.delete();
    check("R11 rdy", usb_even_rdy, 0);
    check("R11 busy", even_busy, 0);

    // R9: unpaired single buffering
    even_irq_clr = 1; cyc(); even_irq_clr = 0;
    ev_write(50, 1, 0);
    check("R9 even busy", even_busy, 1);
    ev_write(51, 0, 0);
    check("R9 even ovf", even_ovf, 1);
    ev_send();
    check("R9 even free", even_busy, 0);
    check("R9 even irq", even_irq, 1);
    ev_write(52, 1, 0);
    ev_send();
    odd_bc_wdata = 33; odd_bc_we = 1; cyc(); odd_bc_we = 0;
    check("R9 odd busy", odd_busy, 1);
    check("R9 odd rdy", usb_odd_rdy, 1);
    check("R9 odd len", int'(usb_odd_len), 33);
    usb_odd_sent = 1; cyc(); usb_odd_sent = 0;
    check("R9 odd free", odd_busy, 0);
    check("R9 odd irq", odd_irq, 1);

    cyc(2);
    check("R2 scoreboard empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule